// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache Controller

This block is a unified cache for a 16-bit processor bus placed in front of a slow main memory. The memory is shared with other bus masters. Instruction fetches and data reads use the same store. Each entry holds one word, a tag and a valid bit. A processor read whose entry is valid and whose tag matches is answered from local storage, and no memory cycle is started. Any other read goes to main memory; the returned word is handed to the processor and, when the address is cacheable, is also written into the entry.

Every processor write goes to main memory. A full-word write also loads the entry. A partial write changes the entry only if it already hits. The block watches for other masters through two inputs: a bus-grant-acknowledge level and a write strobe. The first write strobe seen during a grant clears every valid bit in one clock. Addresses above the cacheable window bypass the store. With the default parameters the store has 1024 entries. Setting `INDEX_W` to 13 gives the 16 KB configuration over a 4 MB window.

Top module: `wt_cache`

## Requirements
- R1: After reset `cpu_ack` and `mem_req` are low and every entry is invalid, so the first read of any address is a miss.
- R2: A read miss raises `mem_req` with `mem_we`=0 and `mem_be`=2'b11 one cycle after the request is sampled. It holds `mem_req` until `mem_ack` and pulses `cpu_ack` in the next cycle, with `cpu_rdata` equal to `mem_rdata`. A cacheable miss fills its entry.
- R3: A cacheable read that finds a valid entry with a matching tag pulses `cpu_ack` one cycle after the request is sampled, returns the stored word and raises no `mem_req`.
- R4: Every processor write raises `mem_req` with `mem_we`=1 and the processor's address, data and byte enables. `cpu_ack` pulses in the cycle after `mem_ack`.
- R5: A cacheable write with `cpu_be`=2'b11 loads the entry and its tag, so a following read of that address hits and returns the written word.
- R6: `cpu_be` bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. A partial write that hits updates only the enabled byte of the entry. A partial write that misses leaves the entry unchanged, so the next read of that address misses.
- R7: While `ext_bgack` is high, the first cycle with `ext_wr` high invalidates all entries. Later `ext_wr` cycles in the same grant do not. A grant without a write, or `ext_wr` with no grant, invalidates nothing.
- R8: A processor request sampled in the same cycle as an invalidation is served as a miss.
- R9: An address with any byte-address bit at or above bit 22 set never hits and never allocates.
- R10: The entry index is byte-address bits [10:1] and the tag is bits [21:11]. A fill to an index replaces the line that held that index before.
- R11: `cpu_ack` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held with its fields until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 2 | Byte lane enables for writes |
| cpu_addr | input | 23 | Word address (byte-address bits 23:1) |
| cpu_wdata | input | 16 | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid while `cpu_ack` is high |
| mem_req | output | 1 | Main-memory request, held until `mem_ack` |
| mem_we | output | 1 | Main-memory write |
| mem_be | output | 2 | Main-memory byte enables |
| mem_addr | output | 23 | Main-memory word address |
| mem_wdata | output | 16 | Main-memory write data |
| mem_ack | input | 1 | Main-memory completion pulse |
| mem_rdata | input | 16 | Main-memory read data, valid with `mem_ack` |
| ext_bgack | input | 1 | Another master owns the bus |
| ext_wr | input | 1 | Write strobe of the external master |

## Verification
The assertions check on every cycle that an invalidation leaves all valid bits clear and fires only once in a row. They also check that uncacheable addresses never report a hit, that a hit completes without a memory request, that a write or a same-cycle invalidation always leads to a memory cycle, and that requests and acknowledges keep their handshake shape. Only the bench scenarios can show that returned data is current. Examples are merged bytes after a partial hit, words changed by an external master after a flush, and the survival of entries filled inside a grant after its first write. The bench follows a reference model of tags and memory over directed and pseudo-random access mixes.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   localparam int LANE_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_DONE = 2'd2
   } wtc_state_e;
endpackage

// File: rtl/wtc_snoop.sv
module wtc_snoop (
   input  logic clk,
   input  logic rst_n,
   input  logic bgack,
   input  logic ext_wr,
   output logic flush
);
   logic wr_seen;

   assign flush = bgack & ext_wr & ~wr_seen;

   always_ff @(posedge clk) begin
      if (!rst_n)      wr_seen <= 1'b0;
      else if (!bgack) wr_seen <= 1'b0;
      else if (ext_wr) wr_seen <= 1'b1;
   end
endmodule

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int INDEX_W = 10,
   parameter int TAG_W   = 11,
   localparam int DEPTH  = 1 << INDEX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [INDEX_W-1:0] idx,
   input  logic               set_en,
   input  logic [TAG_W-1:0]   set_tag,
   output logic [TAG_W-1:0]   rd_tag,
   output logic               rd_vld,
   output logic [DEPTH-1:0]   vld_vec
);
   logic [TAG_W-1:0] tag_arr [DEPTH];

   assign rd_tag = tag_arr[idx];
   assign rd_vld = vld_vec[idx];

   always_ff @(posedge clk) begin
      if (!rst_n)      vld_vec      <= '0;
      else if (flush)  vld_vec      <= '0;
      else if (set_en) vld_vec[idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (set_en) tag_arr[idx] <= set_tag;
   end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int INDEX_W = 10,
   parameter int DATA_W  = 16,
   localparam int LANES  = DATA_W / wtc_pkg::LANE_W,
   localparam int DEPTH  = 1 << INDEX_W
) (
   input  logic               clk,
   input  logic [INDEX_W-1:0] idx,
   input  logic [LANES-1:0]   lane_we,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int LW = wtc_pkg::LANE_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] lane_arr [DEPTH];

      assign rd_data[l*LW +: LW] = lane_arr[idx];

      always_ff @(posedge clk) begin
         if (lane_we[l]) lane_arr[idx] <= wr_data[l*LW +: LW];
      end
   end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl #(
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / wtc_pkg::LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [LANES-1:0]  cpu_be,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              hit,
   input  logic              cacheable,
   input  logic              flush,
   input  logic [DATA_W-1:0] cache_rdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              set_en,
   output logic [LANES-1:0]  lane_we,
   output logic [DATA_W-1:0] fill_data,
   output logic              idle
);
   import wtc_pkg::*;

   wtc_state_e st;
   logic       mem_done;
   logic       full_word;
   logic       local_hit;

   assign idle      = (st == ST_IDLE);
   assign full_word = &cpu_be;
   assign local_hit = hit & ~flush;
   assign mem_done  = (st == ST_MEM) & mem_ack;

   // Fill on read miss, load on full write, merge on partial write hit.
   assign set_en    = mem_done & cacheable & ~flush & (~cpu_we | full_word | hit);
   assign lane_we   = !set_en ? '0 : (cpu_we ? cpu_be : '1);
   assign fill_data = cpu_we ? cpu_wdata : mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cpu_ack   <= 1'b0;
         mem_req   <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               cpu_ack <= 1'b0;
               if (cpu_req) begin
                  if (!cpu_we && local_hit) begin
                     cpu_ack   <= 1'b1;
                     cpu_rdata <= cache_rdata;
                     st        <= ST_DONE;
                  end else begin
                     mem_req <= 1'b1;
                     st      <= ST_MEM;
                  end
               end
            end
            ST_MEM: begin
               if (mem_ack) begin
                  mem_req <= 1'b0;
                  cpu_ack <= 1'b1;
                  if (!cpu_we) cpu_rdata <= mem_rdata;
                  st      <= ST_DONE;
               end
            end
            ST_DONE: begin
               cpu_ack <= 1'b0;
               st      <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 16,
   parameter int SPAN_W  = 22,
   parameter int INDEX_W = 10,
   localparam int LANES  = DATA_W / wtc_pkg::LANE_W,
   localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 0,
   localparam int TAG_W  = SPAN_W - INDEX_W - OFF_W,
   localparam int DEPTH  = 1 << INDEX_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [LANES-1:0]        cpu_be,
   input  logic [ADDR_W-1:OFF_W]   cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic                    cpu_ack,
   output logic [DATA_W-1:0]       cpu_rdata,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [LANES-1:0]        mem_be,
   output logic [ADDR_W-1:OFF_W]   mem_addr,
   output logic [DATA_W-1:0]       mem_wdata,
   input  logic                    mem_ack,
   input  logic [DATA_W-1:0]       mem_rdata,
   input  logic                    ext_bgack,
   input  logic                    ext_wr
);
   if (DATA_W % wtc_pkg::LANE_W != 0 || DATA_W < wtc_pkg::LANE_W) begin : g_bad_width
      $error("wt_cache: DATA_W must be a whole number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wt_cache: SPAN_W leaves no tag bits above the index");
   end
   if (SPAN_W > ADDR_W) begin : g_bad_span
      $error("wt_cache: cacheable span wider than the address");
   end

   logic [INDEX_W-1:0] idx;
   logic [TAG_W-1:0]   req_tag;
   logic [TAG_W-1:0]   rd_tag;
   logic               rd_vld;
   logic [DEPTH-1:0]   vld_vec;
   logic               cacheable;
   logic               hit;
   logic               flush;
   logic               set_en;
   logic [LANES-1:0]   lane_we;
   logic [DATA_W-1:0]  fill_data;
   logic [DATA_W-1:0]  cache_rdata;
   logic               ctrl_idle;

   assign idx     = cpu_addr[OFF_W +: INDEX_W];
   assign req_tag = cpu_addr[OFF_W+INDEX_W +: TAG_W];

   if (ADDR_W > SPAN_W) begin : g_window
      assign cacheable = ~|cpu_addr[ADDR_W-1:SPAN_W];
   end else begin : g_all_cached
      assign cacheable = 1'b1;
   end

   assign hit = cacheable & rd_vld & (rd_tag == req_tag);

   assign mem_we    = cpu_we;
   assign mem_be    = cpu_we ? cpu_be : '1;
   assign mem_addr  = cpu_addr;
   assign mem_wdata = cpu_wdata;

   wtc_snoop u_snoop (
      .clk    (clk),
      .rst_n  (rst_n),
      .bgack  (ext_bgack),
      .ext_wr (ext_wr),
      .flush  (flush)
   );

   wtc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .idx     (idx),
      .set_en  (set_en),
      .set_tag (req_tag),
      .rd_tag  (rd_tag),
      .rd_vld  (rd_vld),
      .vld_vec (vld_vec)
   );

   wtc_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .idx     (idx),
      .lane_we (lane_we),
      .wr_data (fill_data),
      .rd_data (cache_rdata)
   );

   wtc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (cpu_req),
      .cpu_we      (cpu_we),
      .cpu_be      (cpu_be),
      .cpu_wdata   (cpu_wdata),
      .hit         (hit),
      .cacheable   (cacheable),
      .flush       (flush),
      .cache_rdata (cache_rdata),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .cpu_ack     (cpu_ack),
      .cpu_rdata   (cpu_rdata),
      .mem_req     (mem_req),
      .set_en      (set_en),
      .lane_we     (lane_we),
      .fill_data   (fill_data),
      .idle        (ctrl_idle)
   );
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
   parameter int DEPTH = 1024
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req,
   input logic             cpu_we,
   input logic             cpu_ack,
   input logic             mem_req,
   input logic             mem_ack,
   input logic             flush,
   input logic             hit,
   input logic             cacheable,
   input logic             ctrl_idle,
   input logic [DEPTH-1:0] vld_vec
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!cpu_ack && !mem_req && vld_vec == '0));

   a_r2_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req);

   a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_idle && cpu_req && !cpu_we && hit && !flush) |=> (cpu_ack && !mem_req));

   a_r4_write_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_idle && cpu_req && cpu_we) |=> (mem_req && !cpu_ack));

   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_vec == '0));

   a_r7_flush_once: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush);

   a_r8_inval_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_idle && cpu_req && flush) |=> (mem_req && !cpu_ack));

   a_r9_bypass_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !cacheable |-> !hit);

   a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);
endmodule

bind wt_cache wt_cache_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_ack   (cpu_ack),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .flush     (flush),
   .hit       (hit),
   .cacheable (cacheable),
   .ctrl_idle (ctrl_idle),
   .vld_vec   (vld_vec)
);

// File: tb/tb_wt_cache.sv
`timescale 1ns/1ps
module tb_wt_cache;
   localparam int MEM_LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [1:0]  cpu_be = 2'b11;
   logic [23:1] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ack;
   logic [15:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [1:0]  mem_be;
   logic [23:1] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        ext_bgack = 1'b0, ext_wr = 1'b0;

   int total = 0, bad = 0, cycles = 0;
   logic [15:0] mm [int];
   int          c_tag [int];
   logic [15:0] c_dat [int];
   bit          seen = 1'b0;
   int unsigned lcg = 32'h1234_5678;

   always #2.5 clk = ~clk;

   wt_cache dut (.*);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         bad = bad + 1;
         $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
         $display("  test done: total=%0d bad=%0d", total + 1, bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mem_val(input int w);
      return mm.exists(w) ? mm[w] : 16'(w ^ 16'hA5C3 ^ (w >>> 7));
   endfunction

   function automatic bit model_hit(input int a);
      int w = a >>> 1;
      int idx = w & 1023;
      int tg = (w >>> 10) & 11'h7FF;
      return ((a >>> 22) == 0) && c_tag.exists(idx) && c_tag[idx] == tg;
   endfunction

   task automatic model_flush();
      c_tag.delete();
   endtask

   // One processor access; memory responder runs inside the loop.
   task automatic access(input int a, input bit we, input logic [1:0] be,
                         input logic [15:0] wd, input bit snp, input string req);
      int w = a >>> 1;
      int idx = w & 1023;
      int tg = (w >>> 10) & 11'h7FF;
      bit cach = ((a >>> 22) == 0);
      bit exp_hit;
      logic [15:0] exp_d;
      bit got = 0, seen_mem = 0;
      int cyc = 0, wcnt = 0;
      if (snp) model_flush();
      exp_hit = !we && model_hit(a);
      exp_d   = exp_hit ? c_dat[idx] : mem_val(w);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_be = be; cpu_addr = 23'(w); cpu_wdata = wd;
      if (snp) begin ext_bgack = 1; ext_wr = 1; end
      while (!got && cyc < 60) begin
         @(negedge clk);
         cyc++;
         mem_ack = 0;
         if (snp && cyc == 1) begin ext_wr = 0; ext_bgack = 0; end
         if (exp_hit && mem_req) check(0, {req, " hit issued mem_req"}, mem_req, 0);
         if (cpu_ack) begin
            got = 1;
            check(mem_req == 0, {req, " mem_req low at ack"}, mem_req, 0);
         end else if (mem_req) begin
            seen_mem = 1;
            wcnt++;
            if (wcnt == MEM_LAT) begin
               check(mem_addr == 23'(w) && mem_we == we && mem_be == (we ? be : 2'b11),
                     {req, " mem fields"}, {mem_addr, mem_we, mem_be},
                     {23'(w), we, (we ? be : 2'b11)});
               if (we) begin
                  check(mem_wdata == wd, {req, " mem_wdata"}, mem_wdata, wd);
                  mm[w] = mem_val(w);
                  if (be[0]) mm[w][7:0]  = wd[7:0];
                  if (be[1]) mm[w][15:8] = wd[15:8];
               end
               mem_rdata = mem_val(w);
               mem_ack = 1;
            end
         end
      end
      cpu_req = 0;
      check(got, {req, " ack arrived"}, got, 1);
      if (exp_hit) check(cyc == 1 && !seen_mem, {req, " hit latency"}, cyc, 1);
      else         check(cyc == MEM_LAT + 1 && seen_mem, {req, " miss latency"}, cyc, MEM_LAT + 1);
      if (!we) check(cpu_rdata == exp_d, {req, " read data"}, cpu_rdata, exp_d);
      // model update
      if (we) begin
         if (cach && (be == 2'b11 || (c_tag.exists(idx) && c_tag[idx] == tg))) begin
            if (!(c_tag.exists(idx) && c_tag[idx] == tg)) c_dat[idx] = mem_val(w);
            if (be[0]) c_dat[idx][7:0]  = wd[7:0];
            if (be[1]) c_dat[idx][15:8] = wd[15:8];
            c_tag[idx] = tg;
         end
      end else if (!exp_hit && cach) begin
         c_tag[idx] = tg;
         c_dat[idx] = mem_val(w);
      end
      @(negedge clk);
      check(cpu_ack == 0, "R11 ack single pulse", cpu_ack, 0);
   endtask

   task automatic rd(input int a, input string req);
      access(a, 0, 2'b11, 16'h0, 0, req);
   endtask

   task automatic expect_hit(input int a, input bit h, input string req);
      check(model_hit(a) == h, {req, " model precondition"}, model_hit(a), h);
      rd(a, req);
   endtask

   // External master write strobe; also changes memory behind the cache.
   task automatic ext_pulse(input int a, input logic [15:0] d);
      @(negedge clk);
      ext_wr = 1;
      mm[a >>> 1] = d;
      if (ext_bgack && !seen) begin model_flush(); seen = 1; end
      @(negedge clk);
      ext_wr = 0;
   endtask

   task automatic grant(input bit on);
      @(negedge clk);
      ext_bgack = on;
      if (!on) seen = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cpu_ack == 0 && mem_req == 0, "R1 reset outputs", {cpu_ack, mem_req}, 0);
      rst_n = 1;
      @(negedge clk);
      check(cpu_ack == 0 && mem_req == 0, "R1 idle after reset", {cpu_ack, mem_req}, 0);

      expect_hit(32'h0100, 0, "R1 R2 first read misses");
      expect_hit(32'h0100, 1, "R3 repeat read hits");
      access(32'h2000, 1, 2'b11, 16'hBEEF, 0, "R4 full write through");
      expect_hit(32'h2000, 1, "R5 read after full write");
      access(32'h2000, 1, 2'b01, 16'h1177, 0, "R6 low byte write hit");
      expect_hit(32'h2000, 1, "R6 merged low byte");
      access(32'h2000, 1, 2'b10, 16'h22AA, 0, "R6 high byte write hit");
      expect_hit(32'h2000, 1, "R6 merged high byte");
      access(32'h4002, 1, 2'b10, 16'h5500, 0, "R6 byte write miss");
      expect_hit(32'h4002, 0, "R6 no allocate on byte miss");

      expect_hit(32'h0900, 0, "R10 same index other tag");
      expect_hit(32'h0100, 0, "R10 evicted line misses");
      expect_hit(32'h0100, 1, "R10 refilled");

      expect_hit(32'h400100, 0, "R9 uncached read");
      expect_hit(32'h400100, 0, "R9 uncached read again");
      access(32'h400200, 1, 2'b11, 16'h0F0F, 0, "R9 uncached write");
      expect_hit(32'h400200, 0, "R9 uncached write no alloc");

      // R7 flush on first external write in a grant
      expect_hit(32'h2000, 1, "R7 precondition hit");
      ext_pulse(32'h0200, 16'h1111);
      expect_hit(32'h2000, 1, "R7 ext_wr without grant keeps lines");
      grant(1);
      repeat (3) @(negedge clk);
      grant(0);
      expect_hit(32'h2000, 1, "R7 grant without write keeps lines");
      grant(1);
      ext_pulse(32'h2000, 16'h7E57);
      expect_hit(32'h0100, 0, "R7 flushed line misses");
      expect_hit(32'h2000, 0, "R7 flushed line returns new memory");
      ext_pulse(32'h0300, 16'h3333);
      expect_hit(32'h2000, 1, "R7 second write in grant keeps lines");
      grant(0);
      grant(1);
      ext_pulse(32'h0300, 16'h4444);
      grant(0);
      expect_hit(32'h2000, 0, "R7 new grant flushes again");

      // R8 request in the same cycle as an invalidation
      expect_hit(32'h0100, 0, "R8 setup fill");
      check(model_hit(32'h0100), "R8 precondition", 0, 1);
      access(32'h0100, 0, 2'b11, 16'h0, 1, "R8 access during flush");
      expect_hit(32'h0100, 1, "R8 refilled after forced miss");

      // mixed pattern
      for (int i = 0; i < 300; i++) begin
         int a;
         int k;
         lcg = lcg * 32'd1103515245 + 32'd12345;
         k = int'(lcg >> 16);
         a = ((k & 7) << 11) | ((k >>> 3 & 15) << 1);
         if ((k >>> 7 & 15) == 0) a = a | 32'h400000;
         case (k >>> 11 & 3)
            0, 1: rd(a, "R2 R3 R10 mixed read");
            2:    access(a, 1, 2'b11, 16'(k * 7), 0, "R4 R5 mixed write");
            default: access(a, 1, ((k >>> 13 & 1) != 0) ? 2'b01 : 2'b10, 16'(k * 3), 0,
                            "R6 mixed byte write");
         endcase
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule